// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler with Register Scoreboard

This block decides, once per issue slot, which resident warp of a multithreaded SIMT core sends its next instruction to an eight-lane execution group. A 32-thread warp needs four passes over eight lanes, so a slot lasts four clock cycles. Warp w holds threads 32w to 32w+31, and every warp starts at the same program address. The block keeps one program counter per warp. It also keeps a per-warp table of destination registers whose results are still in flight.

Fetch and decode sit outside the block. For each warp they present the next instruction's valid flag, its two source registers, its destination register, whether it writes that destination, and whether it is double precision. The execution side returns a completion pulse, naming a warp and a register, when a result becomes readable. In a real core that pulse arrives a fixed 24 cycles after issue. Warps run in order, and changing from one warp to another costs no cycles. An optional pairing mode lets a second, different warp issue in the same slot.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, `iss_valid`, `iss2_valid`, `iss_warp`, `iss_pc`, `iss2_warp` and `iss2_pc` are all zero. After reset the round-robin pointer sits on the highest warp ID, so warp 0 has first priority.
- R2: An issue decision is taken on the first clock edge after reset is released and on every fourth edge after that. `iss_valid` and `iss2_valid` are one-cycle pulses and stay low on the three edges in between.
- R3: A warp is eligible when all of the following hold: its `dec_valid` bit is 1, neither of its source registers is pending, and, if its write flag is set, its destination register is not pending. A warp whose write flag is 0 ignores the state of its destination register.
- R4: Issuing a warp whose write flag is 1 marks its destination register as pending. A `wb_valid` pulse naming that warp and register clears the mark at that clock edge, so the cleared register counts for the next decision.
- R5: The primary pick is the first eligible warp found when searching upward, with wrap-around, starting just after the warp last issued on the primary output. If any warp is eligible at a decision edge, `iss_valid` is 1.
- R6: If no warp is eligible at a decision edge, `iss_valid` stays low for that slot.
- R7: Each warp's PC starts at `START_PC` and advances by `PC_STEP` every time that warp issues, on either output. `iss_pc` and `iss2_pc` show the issuing warp's PC before the increment.
- R8: With `pair_mode` at 1, the secondary candidate is the next eligible warp after the primary pick in the same wrap-around order. It issues on `iss2_*`, and it is always a different warp from the primary.
- R9: No secondary issue takes place if either the primary pick or the secondary candidate has its double-precision flag set. A primary pick that is double precision still issues alone.
- R10: With `pair_mode` at 0, `iss2_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_mode | input | 1 | Enables a second issue per slot |
| dec_valid | input | N_WARPS | Next instruction present, one bit per warp |
| dec_wr | input | N_WARPS | Next instruction writes its destination |
| dec_dp | input | N_WARPS | Next instruction is double precision |
| dec_dst | input | N_WARPS*RID_W | Destination register, field w at bits [w*RID_W +: RID_W] |
| dec_src_a | input | N_WARPS*RID_W | First source register, same field layout |
| dec_src_b | input | N_WARPS*RID_W | Second source register, same field layout |
| wb_valid | input | 1 | Completion pulse |
| wb_warp | input | WID_W | Warp of the completed write |
| wb_reg | input | RID_W | Register of the completed write |
| iss_valid | output | 1 | Primary issue pulse |
| iss_warp | output | WID_W | Primary warp ID |
| iss_pc | output | PC_W | Primary PC |
| iss2_valid | output | 1 | Secondary issue pulse |
| iss2_warp | output | WID_W | Secondary warp ID |
| iss2_pc | output | PC_W | Secondary PC |

## Verification
A pending mark that is never cleared shows up as a warp that stops issuing. This appears at the first decision edge after its completion pulse, at most four cycles later. A pending mark that was never set lets a dependent warp reissue at the very next slot, well before the completion pulse. A stray round-robin pointer or a wrong PC register shows up at the next issue of the warp concerned, as a wrong warp ID or a wrong PC. An error in pairing shows up within a single slot.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned LANES        = 8;
  localparam int unsigned WARP_THREADS = 32;

  // cycles one warp instruction holds the lane group
  function automatic int unsigned slot_cycles(input int unsigned threads,
                                              input int unsigned lanes);
    return (threads + lanes - 1) / lanes;
  endfunction
endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
  parameter int N_WARPS = 8,
  parameter int N_REGS  = 16,
  localparam int WID_W  = $clog2(N_WARPS),
  localparam int RID_W  = $clog2(N_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_WARPS-1:0]       dec_wr,
  input  logic [N_WARPS*RID_W-1:0] dec_dst,
  input  logic [N_WARPS*RID_W-1:0] dec_src_a,
  input  logic [N_WARPS*RID_W-1:0] dec_src_b,
  input  logic [N_WARPS-1:0]       set_vec,
  input  logic                     wb_valid,
  input  logic [WID_W-1:0]         wb_warp,
  input  logic [RID_W-1:0]         wb_reg,
  output logic [N_WARPS-1:0]       ready
);
  logic [N_REGS-1:0] pend_q [N_WARPS];
  logic [N_REGS-1:0] pend_d [N_WARPS];
  logic [N_WARPS-1:0] upd;

  for (genvar w = 0; w < N_WARPS; w++) begin : g_warp
    logic [RID_W-1:0] dst, sa, sb;
    logic             clr_hit;
    assign dst     = dec_dst[w*RID_W +: RID_W];
    assign sa      = dec_src_a[w*RID_W +: RID_W];
    assign sb      = dec_src_b[w*RID_W +: RID_W];
    assign clr_hit = wb_valid && (wb_warp == WID_W'(w));

    always_comb begin
      pend_d[w] = pend_q[w];
      if (clr_hit) pend_d[w][wb_reg] = 1'b0;
      if (set_vec[w] && dec_wr[w]) pend_d[w][dst] = 1'b1;
    end

    assign upd[w]   = clr_hit || (set_vec[w] && dec_wr[w]);
    assign ready[w] = !pend_q[w][sa] && !pend_q[w][sb] &&
                      !(dec_wr[w] && pend_q[w][dst]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[w] <= '0;
      else if (upd[w]) pend_q[w] <= pend_d[w];
    end
  end
endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N_WARPS = 8,
  localparam int WID_W  = $clog2(N_WARPS)
) (
  input  logic [N_WARPS-1:0] elig,
  input  logic [N_WARPS-1:0] dp,
  input  logic [WID_W-1:0]   last,
  input  logic               pair_en,
  output logic               p1_vld,
  output logic [WID_W-1:0]   p1_id,
  output logic               p2_vld,
  output logic [WID_W-1:0]   p2_id
);
  logic             cand_vld;
  logic [WID_W-1:0] cand_id;

  always_comb begin
    p1_vld = 1'b0;
    p1_id  = '0;
    for (int i = 1; i <= N_WARPS; i++) begin
      logic [WID_W-1:0] idx;
      idx = last + WID_W'(i);
      if (!p1_vld && elig[idx]) begin
        p1_vld = 1'b1;
        p1_id  = idx;
      end
    end
  end

  always_comb begin
    cand_vld = 1'b0;
    cand_id  = '0;
    for (int i = 1; i < N_WARPS; i++) begin
      logic [WID_W-1:0] idx;
      idx = p1_id + WID_W'(i);
      if (!cand_vld && elig[idx]) begin
        cand_vld = 1'b1;
        cand_id  = idx;
      end
    end
  end

  assign p2_id  = cand_id;
  assign p2_vld = pair_en && p1_vld && cand_vld && !dp[p1_id] && !dp[cand_id];
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int N_WARPS  = 8,
  parameter int N_REGS   = 16,
  parameter int PC_W     = 16,
  parameter int START_PC = 'h100,
  parameter int PC_STEP  = 4,
  localparam int WID_W   = $clog2(N_WARPS),
  localparam int RID_W   = $clog2(N_REGS),
  localparam int SLOT_LEN = wis_pkg::slot_cycles(wis_pkg::WARP_THREADS, wis_pkg::LANES),
  localparam int SLOT_W  = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pair_mode,
  input  logic [N_WARPS-1:0]       dec_valid,
  input  logic [N_WARPS-1:0]       dec_wr,
  input  logic [N_WARPS-1:0]       dec_dp,
  input  logic [N_WARPS*RID_W-1:0] dec_dst,
  input  logic [N_WARPS*RID_W-1:0] dec_src_a,
  input  logic [N_WARPS*RID_W-1:0] dec_src_b,
  input  logic                     wb_valid,
  input  logic [WID_W-1:0]         wb_warp,
  input  logic [RID_W-1:0]         wb_reg,
  output logic                     iss_valid,
  output logic [WID_W-1:0]         iss_warp,
  output logic [PC_W-1:0]          iss_pc,
  output logic                     iss2_valid,
  output logic [WID_W-1:0]         iss2_warp,
  output logic [PC_W-1:0]          iss2_pc
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_start;
  logic [WID_W-1:0]  last_q;
  logic [PC_W-1:0]   pc_q [N_WARPS];
  logic [N_WARPS-1:0] ready_w, elig, set_vec;
  logic              p1_vld, p2_vld, go1, go2;
  logic [WID_W-1:0]  p1_id, p2_id;

  // slot timer
  assign slot_start = (slot_q == '0);
  assign slot_d     = (slot_q == SLOT_W'(SLOT_LEN - 1)) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  wis_scoreboard #(.N_WARPS(N_WARPS), .N_REGS(N_REGS)) u_sb (
    .clk(clk), .rst_n(rst_n), .dec_wr(dec_wr), .dec_dst(dec_dst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .set_vec(set_vec),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .ready(ready_w)
  );

  assign elig = dec_valid & ready_w;

  wis_rr_pick #(.N_WARPS(N_WARPS)) u_pick (
    .elig(elig), .dp(dec_dp), .last(last_q), .pair_en(pair_mode),
    .p1_vld(p1_vld), .p1_id(p1_id), .p2_vld(p2_vld), .p2_id(p2_id)
  );

  assign go1 = slot_start && p1_vld;
  assign go2 = slot_start && p2_vld;

  always_comb begin
    set_vec = '0;
    if (go1) set_vec[p1_id] = 1'b1;
    if (go2) set_vec[p2_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_q <= WID_W'(N_WARPS - 1);
    else if (go1) last_q <= p1_id;
  end

  for (genvar w = 0; w < N_WARPS; w++) begin : g_pc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pc_q[w] <= PC_W'(START_PC);
      else if (set_vec[w]) pc_q[w] <= pc_q[w] + PC_W'(PC_STEP);
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_valid  <= 1'b0;
      iss2_valid <= 1'b0;
    end else begin
      iss_valid  <= go1;
      iss2_valid <= go2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_warp <= '0;
      iss_pc   <= '0;
    end else if (go1) begin
      iss_warp <= p1_id;
      iss_pc   <= pc_q[p1_id];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss2_warp <= '0;
      iss2_pc   <= '0;
    end else if (go2) begin
      iss2_warp <= p2_id;
      iss2_pc   <= pc_q[p2_id];
    end
  end
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int N_WARPS = 8,
  localparam int WID_W  = $clog2(N_WARPS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pair_mode,
  input logic [N_WARPS-1:0] dec_valid,
  input logic [N_WARPS-1:0] dec_dp,
  input logic [N_WARPS-1:0] ready_w,
  input logic               slot_start,
  input logic               iss_valid,
  input logic [WID_W-1:0]   iss_warp,
  input logic               iss2_valid,
  input logic [WID_W-1:0]   iss2_warp
);
  logic [N_WARPS-1:0] elig_prev, dp_prev;
  logic               pair_prev, slot_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_prev <= '0;
      dp_prev   <= '0;
      pair_prev <= 1'b0;
      slot_prev <= 1'b0;
    end else begin
      elig_prev <= dec_valid & ready_w;
      dp_prev   <= dec_dp;
      pair_prev <= pair_mode;
      slot_prev <= slot_start;
    end
  end

  // R2
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !iss_valid ##1 !iss_valid ##1 !iss_valid);
  // R3
  elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> elig_prev[iss_warp]);
  // R5
  work_cons_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_prev && (elig_prev != '0)) |-> iss_valid);
  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_prev && (elig_prev == '0)) |-> !iss_valid);
  // R8
  pair_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss2_valid |-> (iss_valid && (iss2_warp != iss_warp) && elig_prev[iss2_warp]));
  // R9
  pair_dp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss2_valid |-> (!dp_prev[iss_warp] && !dp_prev[iss2_warp]));
  // R10
  pair_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_prev |-> !iss2_valid);
endmodule

bind warp_issue_sched wis_checker #(.N_WARPS(N_WARPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .dec_valid(dec_valid),
  .dec_dp(dec_dp), .ready_w(ready_w), .slot_start(slot_start),
  .iss_valid(iss_valid), .iss_warp(iss_warp),
  .iss2_valid(iss2_valid), .iss2_warp(iss2_warp)
);

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;
  localparam int N  = 8;
  localparam int R  = 16;
  localparam int WW = 3;
  localparam int RW = 4;
  localparam int PW = 16;
  localparam int SPC = 'h100;
  localparam int STEP = 4;
  localparam int LAT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pair_mode = 1'b0;
  logic [N-1:0] dec_valid = '0, dec_wr = '0, dec_dp = '0;
  logic [N*RW-1:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
  logic wb_valid = 1'b0;
  logic [WW-1:0] wb_warp = '0;
  logic [RW-1:0] wb_reg = '0;
  logic iss_valid, iss2_valid;
  logic [WW-1:0] iss_warp, iss2_warp;
  logic [PW-1:0] iss_pc, iss2_pc;

  always #2.5 clk = ~clk;

  warp_issue_sched #(.N_WARPS(N), .N_REGS(R), .PC_W(PW), .START_PC(SPC),
                     .PC_STEP(STEP)) u_warp_issue_sched (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .dec_valid(dec_valid),
    .dec_wr(dec_wr), .dec_dp(dec_dp), .dec_dst(dec_dst), .dec_src_a(dec_src_a),
    .dec_src_b(dec_src_b), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_pc(iss_pc),
    .iss2_valid(iss2_valid), .iss2_warp(iss2_warp), .iss2_pc(iss2_pc)
  );

  typedef struct {
    int edge_no; string tag;
    bit v1; int w1; int pc1;
    bit v2; int w2; int pc2;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int edge_cnt = 0;
  string phase = "R5";

  // reference state
  bit [R-1:0] m_pend [N];
  int m_pc [N];
  int m_last = N - 1;
  int m_pos = 0;
  int pd_due[$], pd_w[$], pd_r[$];

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at edge %0d", req, act, exp_v, edge_cnt);
    end
  endtask

  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  // monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].edge_no == edge_cnt) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, int'(iss_valid), int'(e.v1));
      if (e.v1) begin
        check(e.tag, int'(iss_warp), e.w1);
        check("R7", int'(iss_pc), e.pc1);
      end
      check(pair_mode ? e.tag : "R10", int'(iss2_valid), int'(e.v2));
      if (e.v2) begin
        check(e.tag, int'(iss2_warp), e.w2);
        check("R7", int'(iss2_pc), e.pc2);
      end
    end
  end

  function automatic bit m_elig(input int w);
    int d, a, b;
    d = int'(dec_dst[w*RW +: RW]);
    a = int'(dec_src_a[w*RW +: RW]);
    b = int'(dec_src_b[w*RW +: RW]);
    return dec_valid[w] && !m_pend[w][a] && !m_pend[w][b] && !(dec_wr[w] && m_pend[w][d]);
  endfunction

  task automatic set_instr(input int w, input bit v, input bit wr, input bit dp,
                           input int d, input int a, input int b);
    dec_valid[w] = v; dec_wr[w] = wr; dec_dp[w] = dp;
    dec_dst[w*RW +: RW] = RW'(d);
    dec_src_a[w*RW +: RW] = RW'(a);
    dec_src_b[w*RW +: RW] = RW'(b);
  endtask

  // driver: called at a falling edge, predicts the next rising edge
  task automatic step();
    exp_t e;
    int up;
    bit [N-1:0] el;
    up = edge_cnt + 1;
    e.edge_no = up; e.tag = (m_pos == 0) ? phase : "R2";
    e.v1 = 0; e.w1 = 0; e.pc1 = 0; e.v2 = 0; e.w2 = 0; e.pc2 = 0;
    for (int w = 0; w < N; w++) el[w] = m_elig(w);
    if (m_pos == 0) begin
      for (int i = 1; i <= N; i++) begin
        int idx = (m_last + i) % N;
        if (!e.v1 && el[idx]) begin e.v1 = 1; e.w1 = idx; end
      end
      if (e.v1) begin
        bit cv = 0; int cw = 0;
        for (int i = 1; i < N; i++) begin
          int idx = (e.w1 + i) % N;
          if (!cv && el[idx]) begin cv = 1; cw = idx; end
        end
        if (pair_mode && cv && !dec_dp[e.w1] && !dec_dp[cw]) begin
          e.v2 = 1; e.w2 = cw;
        end
      end
    end
    // completion pulse for this edge
    wb_valid = 1'b0;
    for (int i = 0; i < pd_due.size(); i++) begin
      if (pd_due[i] <= up) begin
        wb_valid = 1'b1; wb_warp = WW'(pd_w[i]); wb_reg = RW'(pd_r[i]);
        m_pend[pd_w[i]][pd_r[i]] = 1'b0;
        pd_due.delete(i); pd_w.delete(i); pd_r.delete(i);
        break;
      end
    end
    if (e.v1) begin
      e.pc1 = m_pc[e.w1]; m_pc[e.w1] = (m_pc[e.w1] + STEP) & 16'hFFFF; m_last = e.w1;
      if (dec_wr[e.w1]) begin
        m_pend[e.w1][dec_dst[e.w1*RW +: RW]] = 1'b1;
        pd_due.push_back(up + LAT); pd_w.push_back(e.w1); pd_r.push_back(int'(dec_dst[e.w1*RW +: RW]));
      end
    end
    if (e.v2) begin
      e.pc2 = m_pc[e.w2]; m_pc[e.w2] = (m_pc[e.w2] + STEP) & 16'hFFFF;
      if (dec_wr[e.w2]) begin
        m_pend[e.w2][dec_dst[e.w2*RW +: RW]] = 1'b1;
        pd_due.push_back(up + LAT); pd_w.push_back(e.w2); pd_r.push_back(int'(dec_dst[e.w2*RW +: RW]));
      end
    end
    exp_q.push_back(e);
    m_pos = (m_pos + 1) % 4;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic all_indep(input bit dp_even);
    for (int w = 0; w < N; w++) set_instr(w, 1, 1, dp_even && (w % 2 == 0), 1, 2, 3);
  endtask

  task automatic none_valid();
    for (int w = 0; w < N; w++) set_instr(w, 0, 0, 0, 0, 0, 0);
  endtask

  bit finished = 0;

  initial begin
    for (int w = 0; w < N; w++) begin m_pend[w] = '0; m_pc[w] = SPC; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(iss_valid), 0);
    check("R1", int'(iss2_valid), 0);
    check("R1", int'(iss_pc), 0);
    check("R1", int'(iss_warp), 0);
    all_indep(0);
    rst_n = 1'b1;
    check("R1", int'(iss_valid), 0);
    // R5: all warps ready, round-robin from warp 0
    phase = "R5"; run(80);
    // R3: read-after-write inside one warp stalls until completion
    none_valid(); set_instr(3, 1, 1, 0, 5, 5, 6);
    phase = "R3"; run(70);
    // R3: no write flag, destination state ignored
    none_valid(); set_instr(3, 1, 0, 0, 5, 6, 6);
    run(16);
    // R4: write-after-write stall cleared by the completion pulse
    none_valid(); set_instr(6, 1, 1, 0, 7, 0, 0);
    phase = "R4"; run(64);
    // R6: nothing eligible
    none_valid(); phase = "R6"; run(40);
    // R8: paired issue
    pair_mode = 1'b1; all_indep(0); phase = "R8"; run(80);
    // R9: double-precision blocks pairing
    none_valid(); run(32);
    all_indep(1); phase = "R9"; run(64);
    // R10: pairing switched off again
    pair_mode = 1'b0; all_indep(0); phase = "R10"; run(40);
    none_valid(); phase = "R6"; run(40);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule